// File: doc/BRIEF.md
# Four-Lane Register Renamer with Idiom Elimination

This block is the rename stage of an out-of-order core. Each cycle it takes a group of up to four decoded micro-ops, looks up the physical register that currently holds each source operand, and assigns a physical register to each destination. Architectural-to-physical mappings live in a map table. Unused physical registers are tracked in a free bitmap. Lanes later in a group see the destinations written by earlier lanes of the same group.

Two kinds of operation are finished inside the renamer and never reach an execution port. The first is a same-register XOR or SUBTRACT, whose result is always zero. Its destination is pointed at a dedicated physical register that always reads zero, so the old value is no longer a dependency. The second is a register copy, whose destination is made to share the source's physical register. Each physical register has a small sharing counter. When the counter is full, as happens in a long chain of copies of one value, the copy is not eliminated and runs as an ordinary operation with a fresh register. A release port takes back the physical registers of retired mappings. A shared register returns to the free bitmap only once its last sharer is gone.

If the group needs more fresh registers than are free, the whole group is refused for that cycle.

Top module: `rnm_rename`

## Requirements
- R1: A group of up to four lanes is accepted in one cycle. One cycle after acceptance, `outValid` equals the group's lane mask, and every lane keeps its position. No output appears without an accepted group.
- R2: After reset, every architectural register maps to physical register 0 (the zero register), and physical registers 1 to 31 are free. After reset, `outValid` is 0 and `stall` is 0.
- R3: Operation class encoding is 0 = ordinary ALU, 1 = XOR, 2 = SUBTRACT, 3 = copy of source A. An XOR with a destination and with `srcA == srcB` is eliminated: `outElim` is 1, `outDst` is 0, and no free register is used.
- R4: A SUBTRACT with `srcA == srcB` is eliminated in the same way. Later readers of its destination get physical register 0, so the old value is no longer a dependency.
- R5: A copy whose source register is not full is eliminated. Its `outDst` equals the source's physical register, the source's sharing count goes up by one, and no free register is used.
- R6: A physical register can be shared by at most 3 extra copies (a 2-bit count). A copy of a full register is not eliminated and gets a fresh register. A copy of a register mapped to physical 0 is always eliminated, with `outDst` 0.
- R7: A non-eliminated lane with a destination takes the lowest-numbered free physical register, in lane order. `outOld` is the destination's mapping before the lane.
- R8: A source read by a lane sees the mapping written by any earlier lane of the same group.
- R9: If the fresh registers a group needs are more than the free ones, `stall` is 1 in the same cycle. The group is dropped without any output, and no mapping, count or free bit changes.
- R10: A release with tag 0 is ignored. A released register with a non-zero sharing count has its count lowered by one. Otherwise the register becomes free and can be allocated again.
- R11: A lane without a destination allocates nothing and changes no mapping. Its `outDst` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A group is offered this cycle |
| inLaneOn | input | 4 | Lane mask of the group |
| inOp | input | 8 | Operation class, 2 bits per lane |
| inSrcA | input | 16 | Architectural source A, 4 bits per lane |
| inSrcB | input | 16 | Architectural source B, 4 bits per lane |
| inDst | input | 16 | Architectural destination, 4 bits per lane |
| inHasDst | input | 4 | Lane writes a destination |
| relValid | input | 4 | Release slot valid |
| relTag | input | 20 | Released physical register, 5 bits per slot |
| stall | output | 1 | Group refused this cycle |
| outValid | output | 4 | Renamed lane valid |
| outElim | output | 4 | Lane completed at rename |
| outSrcA | output | 20 | Physical source A per lane |
| outSrcB | output | 20 | Physical source B per lane |
| outDst | output | 20 | Physical destination per lane |
| outOld | output | 20 | Previous physical mapping of the destination |

## Verification
`stall` is a combinational answer for the group on the inputs, so it is checked a moment after the group is driven, in the same cycle. Renamed lanes appear one clock edge after acceptance. Every expected group goes into a queue marked with the cycle it is due in, and the monitor compares it at the falling edge of that cycle. It also flags any output in a cycle when nothing is due. Releases take effect at the next edge, so their effect is seen through the tags and eliminations of the groups that follow.

// File: rtl/rnm_pkg.sv
package rnm_pkg;
  typedef enum logic [1:0] {
    OP_ALU  = 2'd0,
    OP_XOR  = 2'd1,
    OP_SUB  = 2'd2,
    OP_COPY = 2'd3
  } opClass_e;

  // per-lane decode produced by the control
  typedef struct packed {
    logic laneOn;
    logic zeroIdiom;
    logic copyCand;
    logic writesDst;
  } laneDec_t;

  // group-level strobes
  typedef struct packed {
    logic accept;
    logic stall;
  } ctlStrobe_t;
endpackage

// File: rtl/rnm_ctrl.sv
module rnm_ctrl
  import rnm_pkg::*;
#(
  parameter int LANES = 4,
  parameter int AW    = 4
) (
  input  logic                     inValid,
  input  logic [LANES-1:0]         inLaneOn,
  input  logic [LANES*2-1:0]       inOp,
  input  logic [LANES*AW-1:0]      inSrcA,
  input  logic [LANES*AW-1:0]      inSrcB,
  input  logic [LANES-1:0]         inHasDst,
  input  logic                     allocFail,
  output laneDec_t [LANES-1:0]     dec,
  output ctlStrobe_t               strb
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    opClass_e laneOp;
    logic     on, wr, sameSrc;
    assign laneOp  = opClass_e'(inOp[i*2 +: 2]);
    assign on      = inValid & inLaneOn[i];
    assign wr      = on & inHasDst[i];
    assign sameSrc = (inSrcA[i*AW +: AW] == inSrcB[i*AW +: AW]);
    assign dec[i].laneOn    = on;
    assign dec[i].writesDst = wr;
    // R3 / R4: same-register xor or subtract
    assign dec[i].zeroIdiom = wr & sameSrc & ((laneOp == OP_XOR) | (laneOp == OP_SUB));
    // R5: copy candidate
    assign dec[i].copyCand  = wr & (laneOp == OP_COPY);
  end

  assign strb.accept = inValid & ~allocFail;
  assign strb.stall  = inValid & allocFail;
endmodule

// File: rtl/rnm_datapath.sv
module rnm_datapath
  import rnm_pkg::*;
#(
  parameter int LANES = 4,
  parameter int AREGS = 16,
  parameter int PREGS = 32,
  parameter int CNT_W = 2,
  localparam int AW   = $clog2(AREGS),
  localparam int PW   = $clog2(PREGS),
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}}
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  laneDec_t [LANES-1:0]  dec,
  input  ctlStrobe_t            strb,
  input  logic [LANES*AW-1:0]   inSrcA,
  input  logic [LANES*AW-1:0]   inSrcB,
  input  logic [LANES*AW-1:0]   inDst,
  input  logic [LANES-1:0]      relValid,
  input  logic [LANES*PW-1:0]   relTag,
  output logic                  allocFail,
  output logic [LANES-1:0]      outValid,
  output logic [LANES-1:0]      outElim,
  output logic [LANES*PW-1:0]   outSrcA,
  output logic [LANES*PW-1:0]   outSrcB,
  output logic [LANES*PW-1:0]   outDst,
  output logic [LANES*PW-1:0]   outOld
);
  logic [PW-1:0]    mapQ   [AREGS];
  logic [PW-1:0]    mapN   [AREGS];
  logic [CNT_W-1:0] shareQ [PREGS];
  logic [CNT_W-1:0] shareN [PREGS];
  logic [CNT_W-1:0] shareD [PREGS];
  logic [PREGS-1:0] freeQ, availN, freeD;

  logic [PW-1:0]    srcAP [LANES];
  logic [PW-1:0]    srcBP [LANES];
  logic [PW-1:0]    dstP  [LANES];
  logic [PW-1:0]    oldP  [LANES];
  logic [LANES-1:0] elimN, laneOnV;
  logic [PW-1:0]    pick;
  logic             pickOk;

  // Sequential rename across lanes: later lanes see earlier ones (R8)
  always_comb begin : renameComb
    mapN      = mapQ;
    shareN    = shareQ;
    availN    = freeQ;
    allocFail = 1'b0;
    pick      = '0;
    pickOk    = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      laneOnV[i] = dec[i].laneOn;
      srcAP[i]   = mapN[inSrcA[i*AW +: AW]];
      srcBP[i]   = mapN[inSrcB[i*AW +: AW]];
      oldP[i]    = mapN[inDst[i*AW +: AW]];
      dstP[i]    = '0;
      elimN[i]   = 1'b0;
      if (dec[i].writesDst) begin
        if (dec[i].zeroIdiom) begin
          elimN[i] = 1'b1;                       // R3, R4: zero register
        end else if (dec[i].copyCand && srcAP[i] == '0) begin
          elimN[i] = 1'b1;                       // R6: copy of zero
        end else if (dec[i].copyCand && shareN[srcAP[i]] != CMAX) begin
          elimN[i] = 1'b1;                       // R5: share source
          dstP[i]  = srcAP[i];
          shareN[srcAP[i]] = shareN[srcAP[i]] + CNT_W'(1);
        end else begin
          pickOk = 1'b0;
          pick   = '0;
          for (int p = PREGS-1; p > 0; p--) begin
            if (availN[p]) begin
              pickOk = 1'b1;
              pick   = PW'(p);
            end
          end
          if (!pickOk) allocFail = 1'b1;         // R9
          else begin
            dstP[i]      = pick;                 // R7: lowest free
            availN[pick] = 1'b0;
          end
        end
        mapN[inDst[i*AW +: AW]] = dstP[i];
      end
    end
  end

  // Apply accepted rename, then releases (R10)
  always_comb begin : commitComb
    if (strb.accept) begin
      shareD = shareN;
      freeD  = availN;
    end else begin
      shareD = shareQ;
      freeD  = freeQ;
    end
    for (int r = 0; r < LANES; r++) begin
      if (relValid[r] && relTag[r*PW +: PW] != '0) begin
        if (shareD[relTag[r*PW +: PW]] != '0)
          shareD[relTag[r*PW +: PW]] = shareD[relTag[r*PW +: PW]] - CNT_W'(1);
        else
          freeD[relTag[r*PW +: PW]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int a = 0; a < AREGS; a++) mapQ[a] <= '0;     // R2
      for (int p = 0; p < PREGS; p++) shareQ[p] <= '0;
      freeQ    <= {{(PREGS-1){1'b1}}, 1'b0};
      outValid <= '0;
      outElim  <= '0;
      outSrcA  <= '0;
      outSrcB  <= '0;
      outDst   <= '0;
      outOld   <= '0;
    end else begin
      if (strb.accept) mapQ <= mapN;
      shareQ   <= shareD;
      freeQ    <= freeD;
      outValid <= strb.accept ? laneOnV : '0;
      if (strb.accept) begin
        outElim <= elimN;
        for (int i = 0; i < LANES; i++) begin
          outSrcA[i*PW +: PW] <= srcAP[i];
          outSrcB[i*PW +: PW] <= srcBP[i];
          outDst[i*PW +: PW]  <= dstP[i];
          outOld[i*PW +: PW]  <= oldP[i];
        end
      end
    end
  end

  // R2: zero register never enters the free bitmap
  a_r2_zero_reserved: assert property (@(posedge clk) disable iff (!rstN) !freeQ[0]);

  // R9: a refused group leaves the free bitmap unchanged when nothing is released
  a_r9_state_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stall && relValid == '0) |=> $stable(freeQ));

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    // R5: an eliminated lane targets zero or its own source
    a_r5_elim_target: assert property (@(posedge clk) disable iff (!rstN)
      (outValid[i] && outElim[i]) |->
        (outDst[i*PW +: PW] == '0 || outDst[i*PW +: PW] == outSrcA[i*PW +: PW]));
    for (genvar j = i + 1; j < LANES; j++) begin : g_pair
      // R7: fresh registers in one group are distinct
      a_r7_distinct: assert property (@(posedge clk) disable iff (!rstN)
        (outValid[i] && outValid[j] && !outElim[i] && !outElim[j] &&
         outDst[i*PW +: PW] != '0) |-> (outDst[i*PW +: PW] != outDst[j*PW +: PW]));
    end
  end
endmodule

// File: rtl/rnm_rename.sv
module rnm_rename
  import rnm_pkg::*;
#(
  parameter int LANES = 4,
  parameter int AREGS = 16,
  parameter int PREGS = 32,
  parameter int CNT_W = 2,
  localparam int AW   = $clog2(AREGS),
  localparam int PW   = $clog2(PREGS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [LANES-1:0]    inLaneOn,
  input  logic [LANES*2-1:0]  inOp,
  input  logic [LANES*AW-1:0] inSrcA,
  input  logic [LANES*AW-1:0] inSrcB,
  input  logic [LANES*AW-1:0] inDst,
  input  logic [LANES-1:0]    inHasDst,
  input  logic [LANES-1:0]    relValid,
  input  logic [LANES*PW-1:0] relTag,
  output logic                stall,
  output logic [LANES-1:0]    outValid,
  output logic [LANES-1:0]    outElim,
  output logic [LANES*PW-1:0] outSrcA,
  output logic [LANES*PW-1:0] outSrcB,
  output logic [LANES*PW-1:0] outDst,
  output logic [LANES*PW-1:0] outOld
);
  laneDec_t [LANES-1:0] decV;
  ctlStrobe_t           strb;
  logic                 allocFail;

  rnm_ctrl #(.LANES(LANES), .AW(AW)) u_ctrl (
    .inValid(inValid), .inLaneOn(inLaneOn), .inOp(inOp),
    .inSrcA(inSrcA), .inSrcB(inSrcB), .inHasDst(inHasDst),
    .allocFail(allocFail), .dec(decV), .strb(strb)
  );

  rnm_datapath #(.LANES(LANES), .AREGS(AREGS), .PREGS(PREGS), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .dec(decV), .strb(strb),
    .inSrcA(inSrcA), .inSrcB(inSrcB), .inDst(inDst),
    .relValid(relValid), .relTag(relTag), .allocFail(allocFail),
    .outValid(outValid), .outElim(outElim), .outSrcA(outSrcA),
    .outSrcB(outSrcB), .outDst(outDst), .outOld(outOld)
  );

  assign stall = strb.stall;

  // R9: a refused group produces nothing
  a_r9_no_output: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> (outValid == '0));
  // R1: output only after an offered group
  a_r1_out_from_input: assert property (@(posedge clk) disable iff (!rstN)
    (outValid != '0) |-> $past(inValid));
endmodule

// File: tb/tb_rnm_rename.sv
module tb_rnm_rename;
  localparam int CLK_P = 10;
  localparam int L  = 4;
  localparam int AW = 4;
  localparam int PW = 5;

  typedef struct packed {
    logic [L-1:0]         on;
    logic [L-1:0][1:0]    op;
    logic [L-1:0][AW-1:0] a;
    logic [L-1:0][AW-1:0] b;
    logic [L-1:0][AW-1:0] d;
    logic [L-1:0]         hd;
  } grp_t;

  typedef struct packed {
    logic [L-1:0]         v;
    logic [L-1:0]         e;
    logic [L-1:0]         hd;
    logic [L-1:0][PW-1:0] sa;
    logic [L-1:0][PW-1:0] sb;
    logic [L-1:0][PW-1:0] dd;
    logic [L-1:0][PW-1:0] old;
    int                   due;
  } exp_t;

  logic clk = 0, rstN = 0;
  logic inValid = 0;
  logic [L-1:0] inLaneOn = 0, inHasDst = 0, relValid = 0;
  logic [L*2-1:0] inOp = 0;
  logic [L*AW-1:0] inSrcA = 0, inSrcB = 0, inDst = 0;
  logic [L*PW-1:0] relTag = 0;
  logic stall;
  logic [L-1:0] outValid, outElim;
  logic [L*PW-1:0] outSrcA, outSrcB, outDst, outOld;

  rnm_rename dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLaneOn(inLaneOn), .inOp(inOp),
    .inSrcA(inSrcA), .inSrcB(inSrcB), .inDst(inDst), .inHasDst(inHasDst),
    .relValid(relValid), .relTag(relTag), .stall(stall), .outValid(outValid),
    .outElim(outElim), .outSrcA(outSrcA), .outSrcB(outSrcB), .outDst(outDst),
    .outOld(outOld)
  );

  always #(CLK_P/2) clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0, started = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // reference state built from the requirements
  int mMap [16];
  int mShare [32];
  bit mFree [32];
  exp_t expQ[$];
  string tagQ[$];
  int pool[$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d (t=%0t)", req, what, act, expv, $time);
    end
  endtask

  function automatic void modelReset();
    for (int a = 0; a < 16; a++) mMap[a] = 0;
    for (int p = 0; p < 32; p++) begin mShare[p] = 0; mFree[p] = (p != 0); end
  endfunction

  function automatic bit runModel(input grp_t g, output exp_t e);
    int lm [16];
    int ls [32];
    bit lf [32];
    bit fail, found;
    int sa;
    lm = mMap; ls = mShare; lf = mFree; fail = 0; e = '0;
    for (int i = 0; i < L; i++) begin
      if (g.on[i]) begin
        e.v[i]   = 1'b1;
        e.hd[i]  = g.hd[i];
        sa       = lm[g.a[i]];
        e.sa[i]  = PW'(sa);
        e.sb[i]  = PW'(lm[g.b[i]]);
        e.old[i] = PW'(lm[g.d[i]]);
        if (g.hd[i]) begin
          if ((g.op[i] == 2'd1 || g.op[i] == 2'd2) && g.a[i] == g.b[i]) begin
            e.e[i] = 1'b1; e.dd[i] = '0;
          end else if (g.op[i] == 2'd3 && sa == 0) begin
            e.e[i] = 1'b1; e.dd[i] = '0;
          end else if (g.op[i] == 2'd3 && ls[sa] < 3) begin
            e.e[i] = 1'b1; e.dd[i] = PW'(sa); ls[sa]++;
          end else begin
            found = 0;
            for (int p = 1; p < 32; p++)
              if (lf[p] && !found) begin found = 1; lf[p] = 0; e.dd[i] = PW'(p); end
            if (!found) fail = 1;
          end
          lm[g.d[i]] = int'(e.dd[i]);
        end
      end
    end
    if (!fail) begin mMap = lm; mShare = ls; mFree = lf; end
    return fail;
  endfunction

  task automatic sendGroup(input grp_t g, input string tag);
    exp_t e;
    bit stExp;
    @(negedge clk);
    relValid = '0;
    inValid  = 1'b1;
    for (int i = 0; i < L; i++) begin
      inLaneOn[i]          = g.on[i];
      inHasDst[i]          = g.hd[i];
      inOp[i*2 +: 2]       = g.op[i];
      inSrcA[i*AW +: AW]   = g.a[i];
      inSrcB[i*AW +: AW]   = g.b[i];
      inDst[i*AW +: AW]    = g.d[i];
    end
    stExp = runModel(g, e);
    #1;
    chk(stall == stExp, stExp ? "R9" : tag, "stall", int'(stall), int'(stExp));
    if (!stExp) begin
      e.due = cyc + 1;
      expQ.push_back(e);
      tagQ.push_back(tag);
      for (int i = 0; i < L; i++)
        if (g.on[i] && g.hd[i]) pool.push_back(int'(e.old[i]));
    end
  endtask

  task automatic doRelease(input int t0, input int t1, input int t2, input int t3, input logic [L-1:0] m);
    int ts [4];
    ts[0] = t0; ts[1] = t1; ts[2] = t2; ts[3] = t3;
    @(negedge clk);
    inValid  = 1'b0;
    relValid = m;
    for (int r = 0; r < L; r++) begin
      relTag[r*PW +: PW] = PW'(ts[r]);
      if (m[r] && ts[r] != 0) begin
        if (mShare[ts[r]] > 0) mShare[ts[r]]--;
        else mFree[ts[r]] = 1;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inValid = 1'b0; relValid = '0;
    end
  endtask

  // monitor: compare each expected group in the cycle it is due
  exp_t me;
  string mt;
  always @(negedge clk) begin
    if (started && !done) begin
      if (expQ.size() > 0 && expQ[0].due == cyc) begin
        me = expQ.pop_front();
        mt = tagQ.pop_front();
        chk(outValid == me.v, "R1", {mt, " outValid"}, int'(outValid), int'(me.v));
        for (int i = 0; i < L; i++) begin
          if (me.v[i]) begin
            chk(outElim[i] == me.e[i], mt, "elim", int'(outElim[i]), int'(me.e[i]));
            chk(outSrcA[i*PW +: PW] == me.sa[i], mt, "srcA", int'(outSrcA[i*PW +: PW]), int'(me.sa[i]));
            chk(outSrcB[i*PW +: PW] == me.sb[i], mt, "srcB", int'(outSrcB[i*PW +: PW]), int'(me.sb[i]));
            chk(outDst[i*PW +: PW] == me.dd[i], mt, "dst", int'(outDst[i*PW +: PW]), int'(me.dd[i]));
            if (me.hd[i])
              chk(outOld[i*PW +: PW] == me.old[i], mt, "old", int'(outOld[i*PW +: PW]), int'(me.old[i]));
          end
        end
      end else if (outValid != '0) begin
        chk(1'b0, "R1", "unexpected outValid", int'(outValid), 0);
      end
    end
  end

  function automatic grp_t mk(input logic [3:0] on, input logic [3:0] hd);
    grp_t g;
    g = '0; g.on = on; g.hd = hd;
    return g;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    grp_t g;
    int idx, t0, t1, t2, t3;
    logic [3:0] rm;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(outValid == '0, "R2", "reset outValid", int'(outValid), 0);
    chk(stall == 1'b0, "R2", "reset stall", int'(stall), 0);
    started = 1;

    // R2: reads after reset see the zero register; R7: four fresh allocations
    g = mk(4'hF, 4'hF);
    for (int i = 0; i < L; i++) begin g.op[i] = 2'd0; g.d[i] = 4'(i + 1); g.a[i] = 4'(i + 9); g.b[i] = 4'(i); end
    sendGroup(g, "R7 alloc from reset");

    // R3, R4, R8, R5: xor and sub idioms, reader of them, one copy
    g = mk(4'hF, 4'hF);
    g.op[0] = 2'd1; g.a[0] = 4'd5; g.b[0] = 4'd5; g.d[0] = 4'd5;
    g.op[1] = 2'd2; g.a[1] = 4'd6; g.b[1] = 4'd6; g.d[1] = 4'd6;
    g.op[2] = 2'd0; g.a[2] = 4'd5; g.b[2] = 4'd6; g.d[2] = 4'd7;
    g.op[3] = 2'd3; g.a[3] = 4'd1; g.b[3] = 4'd0; g.d[3] = 4'd8;
    sendGroup(g, "R3 R4 R8 idioms");

    // R6: copy chain saturates; copy of zero is eliminated
    g = mk(4'hF, 4'hF);
    g.op = {2'd3, 2'd3, 2'd3, 2'd3};
    g.a[0] = 4'd8;  g.d[0] = 4'd9;
    g.a[1] = 4'd9;  g.d[1] = 4'd10;
    g.a[2] = 4'd10; g.d[2] = 4'd11;
    g.a[3] = 4'd5;  g.d[3] = 4'd12;
    sendGroup(g, "R6 copy chain");

    // R8, R11, R1: partial lane mask, no-destination reader
    g = mk(4'b0101, 4'b0001);
    g.op[0] = 2'd0; g.a[0] = 4'd2; g.b[0] = 4'd2; g.d[0] = 4'd2;
    g.op[2] = 2'd0; g.a[2] = 4'd2; g.b[2] = 4'd11; g.d[2] = 4'd3;
    sendGroup(g, "R11 partial mask");

    // a non-idiom xor with different sources allocates (R3)
    g = mk(4'b0001, 4'b0001);
    g.op[0] = 2'd1; g.a[0] = 4'd1; g.b[0] = 4'd2; g.d[0] = 4'd13;
    sendGroup(g, "R3 xor distinct");

    // R9: exhaust the free registers
    for (int k = 0; k < 8; k++) begin
      g = mk(4'hF, 4'hF);
      for (int i = 0; i < L; i++) begin g.op[i] = 2'd0; g.d[i] = 4'(12 + i); g.a[i] = 4'(i); g.b[i] = 4'(i + 4); end
      sendGroup(g, "R9 exhaust");
    end
    g = mk(4'b0011, 4'b0011);
    g.op[0] = 2'd0; g.d[0] = 4'd14; g.op[1] = 2'd3; g.a[1] = 4'd8; g.d[1] = 4'd15;
    sendGroup(g, "R9 after stall");

    // R10: releases, tag 0 ignored, shared count lowered, then reuse
    doRelease(0, 1, 6, 0, 4'b0111);
    idle(1);
    g = mk(4'b0011, 4'b0011);
    g.op[0] = 2'd3; g.a[0] = 4'd9; g.d[0] = 4'd1;
    g.op[1] = 2'd0; g.d[1] = 4'd2;
    sendGroup(g, "R10 reuse");
    idle(2);

    // random traffic against the reference
    for (int n = 0; n < 400; n++) begin
      g = '0;
      for (int i = 0; i < L; i++) begin
        g.on[i] = ($urandom % 5) != 0;
        g.hd[i] = ($urandom % 6) != 0;
        g.op[i] = 2'($urandom % 4);
        g.a[i]  = 4'($urandom % 16);
        g.b[i]  = (($urandom % 3) == 0) ? g.a[i] : 4'($urandom % 16);
        g.d[i]  = 4'($urandom % 16);
      end
      if (g.on != 0) sendGroup(g, "R8 random");
      if (($urandom % 2) == 0 && pool.size() > 0) begin
        t0 = 0; t1 = 0; t2 = 0; t3 = 0; rm = '0;
        for (int r = 0; r < L; r++) begin
          if (pool.size() > 0) begin
            idx = int'($urandom % pool.size());
            case (r)
              0: t0 = pool[idx];
              1: t1 = pool[idx];
              2: t2 = pool[idx];
              default: t3 = pool[idx];
            endcase
            pool.delete(idx);
            rm[r] = 1'b1;
          end
        end
        doRelease(t0, t1, t2, t3, rm);
      end
    end
    idle(4);
    chk(expQ.size() == 0, "R1", "pending groups", expQ.size(), 0);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule